// File: doc/BRIEF.md
# Floating-Point Control and Status Register Pair

This block holds the two software-visible registers that steer and report a single-precision floating-point unit. The control register carries the rounding-mode selector and a few enable bits. The status register carries five sticky exception flags. Software reaches each register through its own 32-bit write port and write strobe, and the current contents are always visible on a read port. The arithmetic datapath reports exceptions through a 5-bit flag vector with a valid strobe, and those flags accumulate into the status register until software rewrites it.

A mode input chooses how control writes are masked. In standard mode only the low control field is kept. Any write, to either register, that has a bit set in the upper must-be-zero field raises a one-cycle violation pulse, and the masked value is still stored. In compatibility mode the control register keeps every bit except the flag-aligned field, and no violation is reported. The rounding mode and the flag vector are driven straight out to the datapath.

Top module: `fpcsr_top`

## Requirements
- R1: After synchronous active-low reset both registers read zero, the rounding mode is 0 (nearest-even), the flag vector is zero and the violation pulse is low.
- R2: The rounding-mode output equals control bits [1:0], encoded 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R3: In standard mode (legacy_mode=0) a control write stores only write-data bits [6:0]; all higher bits read zero.
- R4: In compatibility mode (legacy_mode=1) a control write stores every write-data bit except [11:7], which read zero (mask 0xFFFFF07F).
- R5: The status register stores only bits [11:7], all other bits read zero; bit 7 is inexact, 8 underflow, 9 overflow, 10 divide-by-zero, 11 invalid, and the flag output equals status bits [11:7].
- R6: On a cycle with dp_flag_valid high, dp_flags (bit 0 inexact to bit 4 invalid) are ORed into the stored flags; with dp_flag_valid low, dp_flags have no effect.
- R7: When a status write and a valid datapath flag update fall in the same cycle, the stored flags become the written bits [11:7] ORed with dp_flags.
- R8: In standard mode, a control or status write with any of bits [31:12] set makes mbz_violation high for exactly the cycle after the write edge, and the masked write still takes effect.
- R9: In compatibility mode no write raises mbz_violation.
- R10: Without a write strobe (and, for status, without a valid flag update) a register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| legacy_mode | input | 1 | 1 selects compatibility masking, 0 standard masking |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data |
| ctl_rdata | output | 32 | Control register contents |
| sts_we | input | 1 | Status register write strobe |
| sts_wdata | input | 32 | Status register write data |
| sts_rdata | output | 32 | Status register contents (flags at bit 7) |
| dp_flag_valid | input | 1 | Datapath flag strobe |
| dp_flags | input | 5 | Datapath exception flags, bit 0 inexact to bit 4 invalid |
| round_mode | output | 2 | Current rounding mode |
| flags | output | 5 | Current sticky flag vector |
| mbz_violation | output | 1 | One-cycle pulse for a write with must-be-zero bits set |

## Verification
The two functions that can land on the same edge are a software status write and a datapath flag update, and the bench drives both strobes in one cycle with disjoint flag bits so that a dropped source shows up as a missing bit. The same cycle also carries a must-be-zero bit in the write data, so the bench judges from one expected item that the violation pulse rises, the masked written flag survives and the datapath flag is merged in. A datapath vector presented without its strobe is judged by reading the status register back unchanged.

// File: rtl/fpcsr_pkg.sv
// Shared sizes and encodings for the floating-point control/status pair.
// Assumes a 32-bit register file view and five exception flags.
package fpcsr_pkg;
    parameter int CSR_W    = 32;  // register width
    parameter int FLAG_N   = 5;   // number of exception flags
    parameter int FLAG_LSB = 7;   // status bit of the first flag
    parameter int CTL_KEEP = 7;   // control bits kept in standard mode
    parameter int MBZ_LSB  = 12;  // lowest must-be-zero bit
    parameter int RM_W     = 2;   // rounding-mode field width

    typedef enum logic [RM_W-1:0] {
        RND_NEAREST_EVEN = 2'd0,
        RND_TOWARD_ZERO  = 2'd1,
        RND_TOWARD_POS   = 2'd2,
        RND_TOWARD_NEG   = 2'd3
    } fp_round_e;

    typedef enum int {
        FLG_INEXACT   = 0,
        FLG_UNDERFLOW = 1,
        FLG_OVERFLOW  = 2,
        FLG_DIVZERO   = 3,
        FLG_INVALID   = 4
    } fp_flag_idx_e;
endpackage

// File: rtl/fpcsr_ctl_reg.sv
// Control register: stores masked write data and exposes the rounding mode.
// Assumes legacy_mode is stable around a write; mask chosen per write.
module fpcsr_ctl_reg
    import fpcsr_pkg::*;
#(
    parameter int DW    = CSR_W,
    parameter int KEEP  = CTL_KEEP,
    parameter int F_LSB = FLAG_LSB,
    parameter int F_N   = FLAG_N,
    parameter int RW    = RM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          legacy_mode,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q,
    output fp_round_e     rm
);
    localparam int F_MSB = F_LSB + F_N - 1;

    logic [DW-1:0] std_mask;
    logic [DW-1:0] leg_mask;

    // Build both write masks bit by bit from the field parameters.
    for (genvar i = 0; i < DW; i++) begin : g_mask
        assign std_mask[i] = (i < KEEP) ? 1'b1 : 1'b0;
        assign leg_mask[i] = (i >= F_LSB && i <= F_MSB) ? 1'b0 : 1'b1;
    end

    // Register update: masked write, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= wdata & (legacy_mode ? leg_mask : std_mask);
    end

    // Decode the rounding field into the shared enum.
    always_comb rm = fp_round_e'(q[RW-1:0]);
endmodule

// File: rtl/fpcsr_sts_reg.sv
// Status register: five sticky flags, written by software, ORed by datapath.
// Assumes datapath flags are only meaningful while their strobe is high.
module fpcsr_sts_reg
    import fpcsr_pkg::*;
#(
    parameter int DW    = CSR_W,
    parameter int F_LSB = FLAG_LSB,
    parameter int F_N   = FLAG_N
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [DW-1:0]  wdata,
    input  logic           dp_valid,
    input  logic [F_N-1:0] dp_flags,
    output logic [F_N-1:0] flags_q,
    output logic [DW-1:0]  rdata
);
    logic [F_N-1:0] base;
    logic [F_N-1:0] merge;

    // Pick written or held flags, then OR in any valid datapath flags.
    always_comb begin
        base  = we ? wdata[F_LSB +: F_N] : flags_q;
        merge = dp_valid ? dp_flags : '0;
    end

    // Sticky flag storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= base | merge;
    end

    // Place flags at their register position, zero elsewhere.
    always_comb begin
        rdata = '0;
        rdata[F_LSB +: F_N] = flags_q;
    end
endmodule

// File: rtl/fpcsr_mbz_check.sv
// Must-be-zero monitor: registers a one-cycle pulse for a standard-mode
// write to either register that sets any bit at or above MBZ_BIT.
module fpcsr_mbz_check
    import fpcsr_pkg::*;
#(
    parameter int DW      = CSR_W,
    parameter int MBZ_BIT = MBZ_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          legacy_mode,
    input  logic          ctl_we,
    input  logic [DW-1:0] ctl_wdata,
    input  logic          sts_we,
    input  logic [DW-1:0] sts_wdata,
    output logic          err
);
    logic ctl_hit;
    logic sts_hit;

    // Detect nonzero reserved field on each strobed write.
    always_comb begin
        ctl_hit = ctl_we && (|ctl_wdata[DW-1:MBZ_BIT]);
        sts_hit = sts_we && (|sts_wdata[DW-1:MBZ_BIT]);
    end

    // Register the pulse; compatibility mode never reports.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else
            err <= !legacy_mode && (ctl_hit || sts_hit);
    end
endmodule

// File: rtl/fpcsr_top.sv
// Floating-point control/status register pair top level.
// Connects control storage, sticky status storage and the reserved-bit monitor.
module fpcsr_top
    import fpcsr_pkg::*;
#(
    parameter int DW  = CSR_W,
    parameter int FN  = FLAG_N,
    parameter int RW  = RM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          legacy_mode,
    input  logic          ctl_we,
    input  logic [DW-1:0] ctl_wdata,
    output logic [DW-1:0] ctl_rdata,
    input  logic          sts_we,
    input  logic [DW-1:0] sts_wdata,
    output logic [DW-1:0] sts_rdata,
    input  logic          dp_flag_valid,
    input  logic [FN-1:0] dp_flags,
    output logic [RW-1:0] round_mode,
    output logic [FN-1:0] flags,
    output logic          mbz_violation
);
    fp_round_e rm_e;

    fpcsr_ctl_reg #(.DW(DW), .KEEP(CTL_KEEP), .F_LSB(FLAG_LSB), .F_N(FN), .RW(RW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
        .we(ctl_we), .wdata(ctl_wdata), .q(ctl_rdata), .rm(rm_e)
    );

    fpcsr_sts_reg #(.DW(DW), .F_LSB(FLAG_LSB), .F_N(FN)) u_sts (
        .clk(clk), .rst_n(rst_n), .we(sts_we), .wdata(sts_wdata),
        .dp_valid(dp_flag_valid), .dp_flags(dp_flags),
        .flags_q(flags), .rdata(sts_rdata)
    );

    fpcsr_mbz_check #(.DW(DW), .MBZ_BIT(MBZ_LSB)) u_mbz (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .sts_we(sts_we), .sts_wdata(sts_wdata), .err(mbz_violation)
    );

    // Export the rounding mode as a plain vector.
    always_comb round_mode = RW'(rm_e);
endmodule

// File: rtl/fpcsr_checker.sv
// Temporal checks on the control/status pair, attached by bind.
module fpcsr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        legacy_mode,
    input logic        ctl_we,
    input logic [31:0] ctl_wdata,
    input logic [31:0] ctl_rdata,
    input logic        sts_we,
    input logic [31:0] sts_rdata,
    input logic        dp_flag_valid,
    input logic [4:0]  dp_flags,
    input logic [1:0]  round_mode,
    input logic [4:0]  flags,
    input logic        mbz_violation
);
    // A pulse only follows a standard-mode write.
    assert_mbz_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mbz_violation |-> $past(ctl_we || sts_we));

    assert_legacy_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mbz_violation |-> !$past(legacy_mode));

    assert_std_ctl_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_we && !legacy_mode) |-> ctl_rdata == {25'd0, $past(ctl_wdata[6:0])});

    assert_sts_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rdata[31:12] == 20'd0 && sts_rdata[6:0] == 7'd0);

    assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sts_we) |-> ((flags & $past(flags)) == $past(flags)));

    assert_dp_flags_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dp_flag_valid) |-> ((flags & $past(dp_flags)) == $past(dp_flags)));

    assert_rm_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctl_we) |-> $stable(round_mode));
endmodule

bind fpcsr_top fpcsr_checker u_chk (.*);

// File: tb/tb_fpcsr_top.sv
// Scoreboard bench: driver pushes expected register images, monitor compares.
`timescale 1ns/1ps
module tb_fpcsr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        legacy_mode = 1'b0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        sts_we = 1'b0;
    logic [31:0] sts_wdata = '0;
    logic [31:0] sts_rdata;
    logic        dp_flag_valid = 1'b0;
    logic [4:0]  dp_flags = '0;
    logic [1:0]  round_mode;
    logic [4:0]  flags;
    logic        mbz_violation;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [31:0] ctl;
        logic [31:0] sts;
        logic        mbz;
        string       tag;
    } exp_t;

    exp_t sb[$];

    logic [31:0] m_ctl = '0;
    logic [4:0]  m_flg = '0;

    always #2 clk = ~clk;

    fpcsr_top dut (.*);

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the model's prediction.
    task automatic step(input logic lg, input logic cwe, input logic [31:0] cwd,
                        input logic swe, input logic [31:0] swd,
                        input logic dv, input logic [4:0] df, input string tag);
        exp_t e;
        @(negedge clk);
        legacy_mode = lg; ctl_we = cwe; ctl_wdata = cwd;
        sts_we = swe; sts_wdata = swd; dp_flag_valid = dv; dp_flags = df;
        if (cwe) m_ctl = cwd & (lg ? 32'hFFFF_F07F : 32'h0000_007F);
        m_flg = (swe ? swd[11:7] : m_flg) | (dv ? df : 5'd0);
        e.ctl = m_ctl;
        e.sts = {20'd0, m_flg, 7'd0};
        e.mbz = !lg && ((cwe && swd_hi(cwd)) || (swe && swd_hi(swd)));
        e.tag = tag;
        sb.push_back(e);
    endtask

    function automatic logic swd_hi(input logic [31:0] v);
        return |v[31:12];
    endfunction

    // Monitor: compare after each edge once registers have settled.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, "ctl_rdata", ctl_rdata, e.ctl);
            chk(e.tag, "sts_rdata", sts_rdata, e.sts);
            chk(e.tag, "round_mode", {30'd0, round_mode}, {30'd0, e.ctl[1:0]});
            chk(e.tag, "flags", {27'd0, flags}, {27'd0, e.sts[11:7]});
            chk(e.tag, "mbz_violation", {31'd0, mbz_violation}, {31'd0, e.mbz});
        end
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, "R1 reset");
        step(0, 1, 32'h1, 0, 0, 0, 0, "R2 toward-zero");
        step(0, 1, 32'h2, 0, 0, 0, 0, "R2 toward-pos");
        step(0, 1, 32'h3, 0, 0, 0, 0, "R2 toward-neg");
        step(0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R3 R8 std ctl mbz");
        step(0, 0, 0, 0, 0, 0, 0, "R8 R10 pulse ends");
        step(1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R4 R9 legacy ctl");
        step(1, 0, 0, 1, 32'hFFFF_FFFF, 0, 0, "R5 R9 legacy sts");
        step(0, 0, 0, 1, 32'h0, 0, 0, "R5 clear");
        step(0, 0, 0, 0, 0, 1, 5'b00001, "R6 inexact");
        step(0, 0, 0, 0, 0, 0, 5'b11110, "R6 strobe low");
        step(0, 0, 0, 0, 0, 1, 5'b10000, "R6 invalid sticky");
        step(0, 0, 0, 1, 32'h1000_0100, 1, 5'b00100, "R7 R8 same cycle");
        step(0, 0, 0, 1, 32'h0000_0400, 0, 0, "R5 divzero");
        step(0, 1, 32'h0000_0055, 0, 0, 0, 0, "R3 low field");
        step(0, 0, 0, 0, 0, 0, 0, "R10 hold");
        @(negedge clk);
        ctl_we = 0; sts_we = 0; dp_flag_valid = 0;
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule